// File: doc/BRIEF.md
# Nibble Accumulator ALU with Skip Request

This block is the arithmetic and logic datapath of a small accumulator-based controller that works on 4-bit words. In each cycle the sequencer presents the current accumulator, the operand read from data memory, an immediate nibble taken from the instruction, a bit index, the carry flag, the carry-save flag and an operation code. The block returns the next accumulator value, the next carry and carry-save flags, and a skip request. When the skip request is high, the sequencer discards the instruction that follows.

The block is purely combinational, so its results are valid in the same cycle that its inputs are applied. The registers for the accumulator and the flags sit in the sequencer. Each operation fixes three things: whether it writes the carry, whether it may raise a skip, and what it puts in the accumulator.

Two operations perform decimal correction. Each adds a fixed constant to the accumulator: 6 after an addition and 10 after a subtraction.

Top module: `nib_alu_core`

## Requirements
- R1: Operation code 1 (plain add) returns (acc + ram) mod 16, ignores the carry input, leaves both flags unchanged, and raises skip when the true sum exceeds 15.
- R2: Operation code 2 (add with carry) returns (acc + ram + carry) mod 16, writes the carry out into the carry flag, and never raises skip.
- R3: Operation code 3 (add with carry and skip) computes the same result and carry flag as code 2, and raises skip exactly when the carry out is 1.
- R4: Operation code 4 returns (acc + 6) mod 16 and code 5 returns (acc + 10) mod 16. Both leave the flags unchanged and never skip.
- R5: Operation code 6 returns acc + 1 and raises skip when acc was 15. Code 7 returns acc - 1 and raises skip when acc was 0. Both leave the flags unchanged.
- R6: Operation code 8 returns the bitwise complement of acc. Code 9 returns its two's-complement negation (complement plus one). Neither changes the flags or skips.
- R7: Operation code 10 returns acc XOR ram, with the flags unchanged and no skip.
- R8: Operation code 11 rotates right through carry. The new acc is {carry, acc[3:1]}, the new carry is acc[0], and the carry-save flag is unchanged.
- R9: Operation code 12 swaps the carry and carry-save flags and leaves the accumulator unchanged.
- R10: Operation code 13 raises skip when acc equals the immediate input. Code 14 raises skip when acc equals ram. Code 15 raises skip when acc[bit_sel] equals ram[bit_sel]. All three leave acc and the flags unchanged.
- R11: Operation code 0 (hold) returns acc and both flags unchanged, with no skip.
- R12: All outputs follow the inputs combinationally, within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (encoding given in R1 to R11) |
| acc_in | input | 4 | Current accumulator |
| ram_in | input | 4 | Operand read from data memory |
| imm_in | input | 4 | Immediate nibble for compare against a constant |
| bit_sel | input | 2 | Bit index for the single-bit compare |
| carry_in | input | 1 | Current carry flag |
| csave_in | input | 1 | Current carry-save flag |
| acc_out | output | 4 | Next accumulator |
| carry_out | output | 1 | Next carry flag |
| csave_out | output | 1 | Next carry-save flag |
| skip_req | output | 1 | Request to discard the next instruction |

## Verification
Every operation code is swept over all accumulator and RAM values, with the carry input both low and high. This separates the adds that use carry in (R2, R3) from the one that ignores it (R1). It also shows which operations write the carry flag and which leave it alone.

The carry-save input and the immediate value are varied against the accumulator. This exposes a swap that is not a true swap (R9) and compares that match on the wrong operand (R10).

Directed corner cases target the wrap points. These are 15 + 1 and 0 - 1 for the skip rules (R5), the 4-bit truncation of both decimal corrections (R4), negation of zero (R6), and a rotate that carries a 1 into bit 3 (R8).

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

    typedef enum logic [3:0] {
        OP_HOLD  = 4'd0,
        OP_ADD   = 4'd1,
        OP_ADDC  = 4'd2,
        OP_ADDCS = 4'd3,
        OP_ADJ_A = 4'd4,
        OP_ADJ_S = 4'd5,
        OP_INC   = 4'd6,
        OP_DEC   = 4'd7,
        OP_CPL   = 4'd8,
        OP_NEG   = 4'd9,
        OP_XOR   = 4'd10,
        OP_ROR   = 4'd11,
        OP_XCY   = 4'd12,
        OP_EQI   = 4'd13,
        OP_EQM   = 4'd14,
        OP_EQB   = 4'd15
    } alu_op_e;

    // Operations allowed to modify the carry or carry-save flag.
    function automatic logic op_writes_flags(alu_op_e o);
        return (o == OP_ADDC) || (o == OP_ADDCS) || (o == OP_ROR) || (o == OP_XCY);
    endfunction

    // Operations allowed to raise a skip request.
    function automatic logic op_may_skip(alu_op_e o);
        return (o == OP_ADD) || (o == OP_ADDCS) || (o == OP_INC) || (o == OP_DEC) ||
               (o == OP_EQI) || (o == OP_EQM) || (o == OP_EQB);
    endfunction

endpackage

// File: rtl/nib_ripple_add.sv
module nib_ripple_add #(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o
);

    logic [DATA_W:0] chain;

    assign chain[0] = cin_i;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign sum_o[i]     = a_i[i] ^ b_i[i] ^ chain[i];
        assign chain[i + 1] = (a_i[i] & b_i[i]) | (chain[i] & (a_i[i] ^ b_i[i]));
    end

    assign cout_o = chain[DATA_W];

endmodule

// File: rtl/nib_logic_unit.sv
module nib_logic_unit #(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] ram_i,
    input  logic              cy_i,
    output logic [DATA_W-1:0] inv_o,
    output logic [DATA_W-1:0] xor_o,
    output logic [DATA_W-1:0] ror_o,
    output logic              ror_cy_o
);

    assign inv_o    = ~acc_i;
    assign xor_o    = acc_i ^ ram_i;
    assign ror_o    = {cy_i, acc_i[DATA_W-1:1]};
    assign ror_cy_o = acc_i[0];

endmodule

// File: rtl/nib_equal.sv
module nib_equal #(
    parameter int DATA_W = 4,
    parameter int SEL_W  = 2
) (
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] ram_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              eq_imm_o,
    output logic              eq_ram_o,
    output logic              eq_bit_o
);

    logic [DATA_W-1:0] match_ram;
    logic [DATA_W-1:0] match_imm;

    for (genvar i = 0; i < DATA_W; i++) begin : g_cmp
        assign match_ram[i] = ~(acc_i[i] ^ ram_i[i]);
        assign match_imm[i] = ~(acc_i[i] ^ imm_i[i]);
    end

    assign eq_ram_o = &match_ram;
    assign eq_imm_o = &match_imm;
    assign eq_bit_o = match_ram[sel_i];

endmodule

// File: rtl/nib_alu_core.sv
module nib_alu_core
    import nib_alu_pkg::*;
#(
    parameter int DATA_W  = 4,
    parameter int ADJ_ADD = 6,
    parameter int ADJ_SUB = 10
) (
    input  logic [3:0]                  op_sel,
    input  logic [DATA_W-1:0]           acc_in,
    input  logic [DATA_W-1:0]           ram_in,
    input  logic [DATA_W-1:0]           imm_in,
    input  logic [$clog2(DATA_W)-1:0]   bit_sel,
    input  logic                        carry_in,
    input  logic                        csave_in,
    output logic [DATA_W-1:0]           acc_out,
    output logic                        carry_out,
    output logic                        csave_out,
    output logic                        skip_req
);

    localparam int SEL_W = $clog2(DATA_W);
    localparam logic [DATA_W-1:0] K_ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] K_ONES = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] K_ADJA = DATA_W'(ADJ_ADD);
    localparam logic [DATA_W-1:0] K_ADJS = DATA_W'(ADJ_SUB);

    alu_op_e op;
    assign op = alu_op_e'(op_sel);

    // Shared adder operand steering
    logic [DATA_W-1:0] add_a, add_b, add_sum;
    logic              add_cin, add_cout;

    // Logic unit and comparator results
    logic [DATA_W-1:0] inv_val, xor_val, ror_val;
    logic              ror_cy;
    logic              eq_imm, eq_ram, eq_bit;

    nib_logic_unit #(.DATA_W(DATA_W)) logic_i (
        .acc_i    (acc_in),
        .ram_i    (ram_in),
        .cy_i     (carry_in),
        .inv_o    (inv_val),
        .xor_o    (xor_val),
        .ror_o    (ror_val),
        .ror_cy_o (ror_cy)
    );

    always_comb begin
        add_a   = acc_in;
        add_b   = ram_in;
        add_cin = 1'b0;
        unique case (op)
            OP_ADDC, OP_ADDCS: add_cin = carry_in;
            OP_ADJ_A:          add_b   = K_ADJA;
            OP_ADJ_S:          add_b   = K_ADJS;
            OP_INC:            add_b   = K_ONE;
            OP_DEC:            add_b   = K_ONES;
            OP_NEG: begin
                add_a = inv_val;
                add_b = K_ONE;
            end
            default: ;
        endcase
    end

    nib_ripple_add #(.DATA_W(DATA_W)) adder_i (
        .a_i    (add_a),
        .b_i    (add_b),
        .cin_i  (add_cin),
        .sum_o  (add_sum),
        .cout_o (add_cout)
    );

    nib_equal #(.DATA_W(DATA_W), .SEL_W(SEL_W)) equal_i (
        .acc_i    (acc_in),
        .ram_i    (ram_in),
        .imm_i    (imm_in),
        .sel_i    (bit_sel),
        .eq_imm_o (eq_imm),
        .eq_ram_o (eq_ram),
        .eq_bit_o (eq_bit)
    );

    // Result selection
    always_comb begin
        acc_out   = acc_in;
        carry_out = carry_in;
        csave_out = csave_in;
        skip_req  = 1'b0;
        unique case (op)
            OP_HOLD: ;
            OP_ADD: begin
                acc_out  = add_sum;
                skip_req = add_cout;
            end
            OP_ADDC: begin
                acc_out   = add_sum;
                carry_out = add_cout;
            end
            OP_ADDCS: begin
                acc_out   = add_sum;
                carry_out = add_cout;
                skip_req  = add_cout;
            end
            OP_ADJ_A, OP_ADJ_S, OP_NEG: acc_out = add_sum;
            OP_INC: begin
                acc_out  = add_sum;
                skip_req = add_cout;
            end
            OP_DEC: begin
                acc_out  = add_sum;
                skip_req = ~add_cout;
            end
            OP_CPL: acc_out = inv_val;
            OP_XOR: acc_out = xor_val;
            OP_ROR: begin
                acc_out   = ror_val;
                carry_out = ror_cy;
            end
            OP_XCY: begin
                carry_out = csave_in;
                csave_out = carry_in;
            end
            OP_EQI: skip_req = eq_imm;
            OP_EQM: skip_req = eq_ram;
            OP_EQB: skip_req = eq_bit;
            default: ;
        endcase
    end

    // Guards on the result selection
    always_comb begin
        if (!$isunknown({op_sel, acc_in, ram_in, imm_in, bit_sel, carry_in, csave_in})) begin
            if (op == OP_ADDC)
                a_r2_addc_no_skip: assert (!skip_req);
            if (!op_writes_flags(op))
                a_r11_flags_hold: assert (carry_out == carry_in && csave_out == csave_in);
            if (!op_may_skip(op))
                a_r11_no_stray_skip: assert (!skip_req);
            if (op == OP_INC && skip_req)
                a_r5_inc_wraps: assert (acc_out == '0);
            if (op == OP_DEC && skip_req)
                a_r5_dec_wraps: assert (acc_out == K_ONES);
            if (op == OP_NEG)
                a_r6_neg_sums_zero: assert (DATA_W'(acc_out + acc_in) == '0);
            if (op == OP_ROR)
                a_r8_ror_bit0: assert (carry_out == acc_in[0] && acc_out[DATA_W-1] == carry_in);
            if (op == OP_EQI || op == OP_EQM || op == OP_EQB)
                a_r10_cmp_keeps_acc: assert (acc_out == acc_in);
        end
    end

endmodule

// File: tb/nib_alu_core_tb_top.sv
module nib_alu_core_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [3:0] op_sel   = 4'd0;
    logic [3:0] acc_in   = 4'd0;
    logic [3:0] ram_in   = 4'd0;
    logic [3:0] imm_in   = 4'd0;
    logic [1:0] bit_sel  = 2'd0;
    logic       carry_in = 1'b0;
    logic       csave_in = 1'b0;
    logic [3:0] acc_out;
    logic       carry_out, csave_out, skip_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    nib_alu_core dut_i (
        .op_sel   (op_sel),
        .acc_in   (acc_in),
        .ram_in   (ram_in),
        .imm_in   (imm_in),
        .bit_sel  (bit_sel),
        .carry_in (carry_in),
        .csave_in (csave_in),
        .acc_out  (acc_out),
        .carry_out(carry_out),
        .csave_out(csave_out),
        .skip_req (skip_req)
    );

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0:        return "R11";
            4'd1:        return "R1";
            4'd2:        return "R2";
            4'd3:        return "R3";
            4'd4, 4'd5:  return "R4";
            4'd6, 4'd7:  return "R5";
            4'd8, 4'd9:  return "R6";
            4'd10:       return "R7";
            4'd11:       return "R8";
            4'd12:       return "R9";
            default:     return "R10";
        endcase
    endfunction

    // Expected {acc, carry, csave, skip} from the requirement text
    function automatic logic [6:0] model(input logic [3:0] o, a, m, i,
                                         input logic [1:0] s, input logic c, cs);
        int sum;
        logic [3:0] r  = a;
        logic       nc = c;
        logic       ns = cs;
        logic       sk = 1'b0;
        case (o)
            4'd1:  begin sum = a + m;     r = 4'(sum); sk = (sum > 15); end
            4'd2:  begin sum = a + m + c; r = 4'(sum); nc = (sum > 15); end
            4'd3:  begin sum = a + m + c; r = 4'(sum); nc = (sum > 15); sk = nc; end
            4'd4:  r = 4'(a + 6);
            4'd5:  r = 4'(a + 10);
            4'd6:  begin r = 4'(a + 1); sk = (a == 4'd15); end
            4'd7:  begin r = 4'(a - 1); sk = (a == 4'd0); end
            4'd8:  r = ~a;
            4'd9:  r = 4'(16 - a);
            4'd10: r = a ^ m;
            4'd11: begin r = {c, a[3:1]}; nc = a[0]; end
            4'd12: begin nc = cs; ns = c; end
            4'd13: sk = (a == i);
            4'd14: sk = (a == m);
            4'd15: sk = (a[s] == m[s]);
            default: ;
        endcase
        return {r, nc, ns, sk};
    endfunction

    task automatic apply_check(input logic [3:0] o, a, m, i, input logic [1:0] s,
                               input logic c, cs, input logic [6:0] exp, input string tag);
        @(negedge clk);
        op_sel = o; acc_in = a; ram_in = m; imm_in = i; bit_sel = s;
        carry_in = c; csave_in = cs;
        #2;
        n_checks++;
        if ({acc_out, carry_out, csave_out, skip_req} !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d acc=%h ram=%h: got acc=%h cy=%b cs=%b skip=%b expected acc=%h cy=%b cs=%b skip=%b",
                     tag, o, a, m, acc_out, carry_out, csave_out, skip_req,
                     exp[6:3], exp[2], exp[1], exp[0]);
        end
    endtask

    // Reset-time and hold behaviour (R11)
    task automatic t_hold_at_reset();
        apply_check(4'd0, 4'd0, 4'd0, 4'd0, 2'd0, 1'b0, 1'b0, 7'b0000_000, "R11");
        apply_check(4'd0, 4'hA, 4'h5, 4'h3, 2'd1, 1'b1, 1'b0, {4'hA, 1'b1, 1'b0, 1'b0}, "R11");
    endtask

    // Exhaustive sweep of one operation over acc, ram and carry (R12: same-cycle)
    task automatic t_sweep(input logic [3:0] o);
        for (int a = 0; a < 16; a++) begin
            for (int m = 0; m < 16; m++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [3:0] av = 4'(a);
                    logic [3:0] mv = 4'(m);
                    logic [3:0] iv = 4'(a + (m & 3));
                    logic [1:0] sv = mv[3:2] ^ av[1:0];
                    logic       cv = 1'(c);
                    logic       sav = cv ^ av[0];
                    apply_check(o, av, mv, iv, sv, cv, sav,
                                model(o, av, mv, iv, sv, cv, sav), req_of(o));
                end
            end
        end
    endtask

    // Hand-worked corner cases
    task automatic t_corners();
        apply_check(4'd1,  4'h9, 4'h7, 4'h0, 2'd0, 1'b1, 1'b0, {4'h0, 1'b1, 1'b0, 1'b1}, "R1");
        apply_check(4'd2,  4'hF, 4'h0, 4'h0, 2'd0, 1'b1, 1'b0, {4'h0, 1'b1, 1'b0, 1'b0}, "R2");
        apply_check(4'd3,  4'h8, 4'h8, 4'h0, 2'd0, 1'b0, 1'b1, {4'h0, 1'b1, 1'b1, 1'b1}, "R3");
        apply_check(4'd4,  4'hC, 4'h0, 4'h0, 2'd0, 1'b0, 1'b0, {4'h2, 1'b0, 1'b0, 1'b0}, "R4");
        apply_check(4'd5,  4'h7, 4'h0, 4'h0, 2'd0, 1'b1, 1'b1, {4'h1, 1'b1, 1'b1, 1'b0}, "R4");
        apply_check(4'd6,  4'hF, 4'h0, 4'h0, 2'd0, 1'b0, 1'b0, {4'h0, 1'b0, 1'b0, 1'b1}, "R5");
        apply_check(4'd7,  4'h0, 4'h0, 4'h0, 2'd0, 1'b0, 1'b0, {4'hF, 1'b0, 1'b0, 1'b1}, "R5");
        apply_check(4'd9,  4'h0, 4'h0, 4'h0, 2'd0, 1'b0, 1'b0, {4'h0, 1'b0, 1'b0, 1'b0}, "R6");
        apply_check(4'd9,  4'h3, 4'h0, 4'h0, 2'd0, 1'b0, 1'b0, {4'hD, 1'b0, 1'b0, 1'b0}, "R6");
        apply_check(4'd11, 4'h1, 4'h0, 4'h0, 2'd0, 1'b1, 1'b0, {4'h8, 1'b1, 1'b0, 1'b0}, "R8");
        apply_check(4'd12, 4'h5, 4'h0, 4'h0, 2'd0, 1'b1, 1'b0, {4'h5, 1'b0, 1'b1, 1'b0}, "R9");
        apply_check(4'd13, 4'h6, 4'h0, 4'h6, 2'd0, 1'b0, 1'b0, {4'h6, 1'b0, 1'b0, 1'b1}, "R10");
        apply_check(4'd15, 4'h8, 4'h9, 4'h0, 2'd3, 1'b0, 1'b0, {4'h8, 1'b0, 1'b0, 1'b1}, "R10");
        apply_check(4'd15, 4'h8, 4'h9, 4'h0, 2'd0, 1'b0, 1'b0, {4'h8, 1'b0, 1'b0, 1'b0}, "R10");
    endtask

    initial begin
        t_hold_at_reset();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        for (int o = 0; o < 16; o++) t_sweep(4'(o));
        t_corners();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule